// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block sits behind a user data register of a JTAG TAP. It turns the bit stream that a host shifts through that register into one SPI transaction to a serial flash. Everything is clocked by the gated data-register clock `drck`. A scan first carries a 48-bit header: a 32-bit sync word, then a 16-bit payload length in bits, both most significant bit first. When the most recent 48 shifted bits form the sync word plus a length, the bridge selects the flash. It then forwards exactly that many following `tdi` bits on MOSI and clocks them with a gated copy of `drck`. Each bit the flash returns on MISO appears on `tdo`, so the host reads flash responses back in the same scan.

The header register is emptied at the start of every scan. The first shift edge after a clear loads `tdi` over all-zero contents. Bits left over from an earlier scan therefore never join new bits to form a false sync. Only one transfer happens per scan. After a match, further sync patterns in the stream are ignored until the TAP leaves the shift phase. Chip select and the SCK enable change on the falling edge of `drck`, so each SCK pulse lies completely inside the chip-select window.

Top module: `jtag_spi_bridge`

## Requirements
- R1: A rising `drck` edge that samples a clear condition (`capture`, `update` or `tap_reset` high, or `sel` low) discards all header progress and any transfer. While the condition lasts, from the next falling edge on, `spi_cs_n` is 1 (deselected), `spi_sck` is 0 and `spi_mosi` is 0.
- R2: The first rising edge after a clear restarts the header from the current `tdi` bit alone. Bits from an earlier scan never take part in a match, even when that scan ended in the lower half of the sync word.
- R3: The header is the 32-bit sync word followed by a 16-bit length N, each sent MSB first. The match is decided on the rising edge that shifts in the last length bit. `spi_cs_n` goes to 0 at the falling edge right after that rising edge.
- R4: `spi_cs_n` stays 0 for exactly N `drck` cycles and then returns to 1. During the window, `spi_sck` makes exactly N rising transitions, each one on a rising `drck` edge.
- R5: While `spi_cs_n` is 0, `spi_mosi` equals `tdi`. The first payload bit is the `tdi` bit that follows the last length bit. Outside the window `spi_mosi` is 0.
- R6: On every `spi_sck` rising edge the bridge samples `spi_miso`. From then until the next such edge, `tdo` shows the sampled value.
- R7: A header with N = 0 is consumed but never asserts `spi_cs_n` or pulses `spi_sck`.
- R8: Any number of leading bits may come before the sync word. The search slides one bit per edge, and a match occurs once the last 48 shifted bits form the sync word and a length.
- R9: After a match, the rest of the scan, including a complete second header, starts no further transfer until the next clear.
- R10: A clear condition during a transfer ends it. The rising edge that samples the clear carries the last `spi_sck` rise, and `spi_cs_n` returns to 1 at the next falling edge.
- R11: The sync word is a parameter. The bridge behaves the same with a word whose two 16-bit halves differ and with a word whose halves repeat (for example 0x59A659A6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drck | input | 1 | Data-register shift clock from the TAP |
| sel | input | 1 | User register selected (active high) |
| capture | input | 1 | TAP in capture state |
| update | input | 1 | TAP in update state |
| tap_reset | input | 1 | TAP in test-logic reset |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial data back to the host (captured MISO) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
The bench builds two copies of the bridge with the default 32-bit sync and 16-bit length widths. One uses the distinct-half sync word 0x59A659A3 and the other the repeated-half word 0x59A659A6. With short payload lengths (0 to 40 bits), every cycle of each chip-select window, every MOSI bit and every returned MISO bit can be compared against a window computed from the header position. This is done across leading-bit offsets and lengths for both sync words. The same small setup makes it cheap to cover the hazard sequence, in which one scan ends in 0x59A6 and the next opens with the repeated sync word, as well as a second header placed inside one scan and clears of all three kinds in the middle of a transfer.

// File: rtl/jsb_pkg.sv
package jsb_pkg;

    // default header geometry: sync word then payload length
    localparam int SYNC_W_DEF = 32;
    localparam int LEN_W_DEF  = 16;

    // default sync word, two different 16-bit halves
    localparam logic [SYNC_W_DEF-1:0] SYNC_WORD_DEF = 32'h59A6_59A3;

endpackage

// File: rtl/jsb_header.sv
module jsb_header #(
    parameter int                SYNC_W    = jsb_pkg::SYNC_W_DEF,
    parameter int                LEN_W     = jsb_pkg::LEN_W_DEF,
    parameter logic [SYNC_W-1:0] SYNC_WORD = jsb_pkg::SYNC_WORD_DEF
) (
    input  logic             drck,
    input  logic             scan_clear,
    input  logic             tdi,
    output logic             hit,
    output logic [LEN_W-1:0] len,
    output logic             found
);
    localparam int HDR_W = SYNC_W + LEN_W;

    typedef struct packed {
        logic [HDR_W-2:0] hdr;    // bits kept for the next shift
        logic             fresh;  // next edge starts a new header
        logic             found;  // sync seen in this scan
    } hdr_st_t;

    hdr_st_t          st_d, st_q;
    logic [HDR_W-1:0] window;

    always_comb begin
        // header as it stands once this edge has shifted tdi in
        if (st_q.fresh) window = {{(HDR_W-1){1'b0}}, tdi};
        else            window = {st_q.hdr, tdi};

        st_d = st_q;
        hit  = 1'b0;
        if (scan_clear) begin
            st_d.fresh = 1'b1;
            st_d.found = 1'b0;
        end else begin
            st_d.hdr   = window[HDR_W-2:0];
            st_d.fresh = 1'b0;
            if (!st_q.found && (window[HDR_W-1 -: SYNC_W] == SYNC_WORD)) begin
                hit        = 1'b1;
                st_d.found = 1'b1;
            end
        end
    end

    always_ff @(posedge drck) begin
        st_q <= st_d;
    end

    assign len   = window[LEN_W-1:0];
    assign found = st_q.found;

    // R9
    found_hold_chk: assert property (@(posedge drck) disable iff (scan_clear)
        st_q.found |=> st_q.found);

endmodule

// File: rtl/jsb_xfer.sv
module jsb_xfer #(
    parameter int LEN_W = jsb_pkg::LEN_W_DEF
) (
    input  logic             drck,
    input  logic             scan_clear,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    output logic             lane
);
    typedef struct packed {
        logic [LEN_W-1:0] remain;  // payload bits still to move
    } xfer_st_t;

    xfer_st_t st_d, st_q;
    logic     lane_d, lane_q;

    always_comb begin
        st_d = st_q;
        if (scan_clear)               st_d.remain = '0;
        else if (load)                st_d.remain = len_in;
        else if (st_q.remain != '0)   st_d.remain = st_q.remain - 1'b1;
    end

    always_ff @(posedge drck) begin
        st_q <= st_d;
    end

    // chip-select window moves on the falling edge so SCK pulses sit inside it
    always_comb begin
        lane_d = (st_q.remain != '0);
    end

    always_ff @(negedge drck) begin
        lane_q <= lane_d;
    end

    assign lane = lane_q;

    // R9
    load_idle_chk: assert property (@(posedge drck) disable iff (scan_clear)
        load |-> (st_q.remain == '0));

endmodule

// File: rtl/jsb_return.sv
module jsb_return (
    input  logic drck,
    input  logic lane,
    input  logic miso,
    output logic tdo
);
    typedef struct packed {
        logic tdo;  // last MISO bit taken on an SCK rise
    } ret_st_t;

    ret_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lane) st_d.tdo = miso;
    end

    always_ff @(posedge drck) begin
        st_q <= st_d;
    end

    assign tdo = st_q.tdo;

endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge #(
    parameter int                SYNC_W    = jsb_pkg::SYNC_W_DEF,
    parameter int                LEN_W     = jsb_pkg::LEN_W_DEF,
    parameter logic [SYNC_W-1:0] SYNC_WORD = jsb_pkg::SYNC_WORD_DEF
) (
    input  logic drck,
    input  logic sel,
    input  logic capture,
    input  logic update,
    input  logic tap_reset,
    input  logic tdi,
    output logic tdo,
    output logic spi_cs_n,
    output logic spi_sck,
    output logic spi_mosi,
    input  logic spi_miso
);
    logic             scan_clear;
    logic             hit;
    logic             found;
    logic [LEN_W-1:0] len;
    logic             lane;

    assign scan_clear = capture | update | tap_reset | ~sel;

    jsb_header #(
        .SYNC_W    (SYNC_W),
        .LEN_W     (LEN_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_hdr (
        .drck       (drck),
        .scan_clear (scan_clear),
        .tdi        (tdi),
        .hit        (hit),
        .len        (len),
        .found      (found)
    );

    jsb_xfer #(
        .LEN_W (LEN_W)
    ) u_xfer (
        .drck       (drck),
        .scan_clear (scan_clear),
        .load       (hit),
        .len_in     (len),
        .lane       (lane)
    );

    jsb_return u_ret (
        .drck (drck),
        .lane (lane),
        .miso (spi_miso),
        .tdo  (tdo)
    );

    assign spi_cs_n = ~lane;
    assign spi_sck  = drck & lane;
    assign spi_mosi = tdi & lane;

    // R4
    cs_needs_found_chk: assert property (@(posedge drck) disable iff (scan_clear)
        !spi_cs_n |-> found);

    // R3
    hit_selects_chk: assert property (@(posedge drck) disable iff (scan_clear)
        (hit && (len != '0)) |=> !spi_cs_n);

    // R7
    zero_len_idle_chk: assert property (@(posedge drck) disable iff (scan_clear)
        (hit && (len == '0)) |=> spi_cs_n);

endmodule

// File: tb/jtag_spi_bridge_bench.sv
module jtag_spi_bridge_bench;
    localparam logic [31:0] SYNC_A = 32'h59A659A3;
    localparam logic [31:0] SYNC_B = 32'h59A659A6;

    logic drck = 1'b0;
    always #5 drck = ~drck;

    logic sel, capture, update, tap_reset, tdi, miso;
    logic tdo0, cs0, sck0, mosi0;
    logic tdo1, cs1, sck1, mosi1;

    jtag_spi_bridge #(.SYNC_WORD(SYNC_A)) u_jtag_spi_bridge (
        .drck(drck), .sel(sel), .capture(capture), .update(update),
        .tap_reset(tap_reset), .tdi(tdi), .tdo(tdo0), .spi_cs_n(cs0),
        .spi_sck(sck0), .spi_mosi(mosi0), .spi_miso(miso));

    jtag_spi_bridge #(.SYNC_WORD(SYNC_B)) u_jtag_spi_bridge_rep (
        .drck(drck), .sel(sel), .capture(capture), .update(update),
        .tap_reset(tap_reset), .tdi(tdi), .tdo(tdo1), .spi_cs_n(cs1),
        .spi_sck(sck1), .spi_mosi(mosi1), .spi_miso(miso));

    int n_checks = 0;
    int n_fail   = 0;
    int sck_cnt0 = 0;
    int sck_cnt1 = 0;
    int cyc      = 0;
    bit done     = 0;
    bit sbits[$];

    always @(posedge sck0) sck_cnt0++;
    always @(posedge sck1) sck_cnt1++;

    always @(posedge drck) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(bit ok, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic push(logic [63:0] v, int w);
        for (int i = w - 1; i >= 0; i--) sbits.push_back(v[i]);
    endtask

    function automatic bit inwin(int k, int em, int n, int ab);
        return (k >= em) && (k < em + n) && ((ab < 0) || (k <= ab));
    endfunction

    function automatic bit pay_bit(int j, int n);
        return ((j * 3 + n) % 5) < 2;
    endfunction

    function automatic bit resp_bit(int j, int n);
        return ((((j * 7) + 1) % 3) == 0) ^ n[0];
    endfunction

    task automatic build_frame(logic [31:0] sync, int lead_w, logic [63:0] lead_v,
                               int n, int tail);
        sbits.delete();
        if (lead_w > 0) push(lead_v, lead_w);
        push({32'd0, sync}, 32);
        push(64'(n), 16);
        for (int j = 0; j < n; j++) sbits.push_back(pay_bit(j, n));
        for (int j = 0; j < tail; j++) sbits.push_back(1'b0);
    endtask

    // one scan: clear, shift sbits, compare every cycle against the expected window
    task automatic run_scan(int which, int em, int n, int ab, int ab_kind, string tag);
        int  len_s = sbits.size();
        int  w = 0;
        int  e_cs = 0, e_mo = 0, e_td = 0;
        int  a_cs = 0, x_cs = 0, a_mo = 0, x_mo = 0, a_td = 0, x_td = 0;
        int  cnt;
        bit  prev_m = 0;
        capture = 1; update = 0; tap_reset = 0; sel = 1; tdi = 0; miso = 0;
        @(negedge drck);
        capture = 0;
        sck_cnt0 = 0;
        sck_cnt1 = 0;
        for (int k = 0; k <= len_s; k++) begin
            bit last = (k == len_s) || ((ab >= 0) && (k == ab + 1));
            bit on   = inwin(k, em, n, ab);
            bit exp_m;
            logic c, m, t;
            update = 0; sel = 1; tap_reset = 0;
            if (last) begin
                capture = 1;
                tdi = 0;
            end else begin
                tdi = sbits[k];
            end
            if ((ab >= 0) && (k == ab)) begin
                case (ab_kind)
                    0:       update = 1;
                    1:       sel = 0;
                    default: tap_reset = 1;
                endcase
            end
            miso = on ? resp_bit(k - em, n) : 1'b0;
            #1;
            c = which ? cs1 : cs0;
            m = which ? mosi1 : mosi0;
            t = which ? tdo1 : tdo0;
            exp_m = on ? sbits[k] : 1'b0;
            if (c !== !on) begin
                if (e_cs == 0) begin a_cs = int'(c); x_cs = int'(!on); end
                e_cs++;
            end
            if (m !== exp_m) begin
                if (e_mo == 0) begin a_mo = int'(m); x_mo = int'(exp_m); end
                e_mo++;
            end
            if (k > 0 && inwin(k - 1, em, n, ab) && (t !== prev_m)) begin
                if (e_td == 0) begin a_td = int'(t); x_td = int'(prev_m); end
                e_td++;
            end
            if (on) w++;
            prev_m = miso;
            if (last) break;
            @(negedge drck);
        end
        cnt = which ? sck_cnt1 : sck_cnt0;
        check(e_cs == 0, {tag, " R3 R4 chip-select window"}, a_cs, x_cs);
        check(e_mo == 0, {tag, " R5 mosi payload"}, a_mo, x_mo);
        check(e_td == 0, {tag, " R6 tdo returns miso"}, a_td, x_td);
        check(cnt == w, {tag, " R4 sck pulse count"}, cnt, w);
    endtask

    int lens[5] = '{0, 1, 2, 5, 13};

    initial begin
        sel = 0; capture = 1; update = 0; tap_reset = 1; tdi = 0; miso = 0;
        repeat (3) @(negedge drck);
        #1;
        check(cs0 === 1'b1 && cs1 === 1'b1, "R1 reset cs_n high", int'(cs0 & cs1), 1);
        check(sck0 === 1'b0 && sck1 === 1'b0, "R1 reset sck low", int'(sck0 | sck1), 0);
        check(mosi0 === 1'b0 && mosi1 === 1'b0, "R1 reset mosi low", int'(mosi0 | mosi1), 0);
        @(negedge drck);
        tap_reset = 0; sel = 1;

        // R3 R4 R7 R11: lead offsets x lengths on both sync words
        for (int d = 0; d < 2; d++)
            for (int lead = 0; lead < 4; lead++)
                for (int ni = 0; ni < 5; ni++) begin
                    int n = lens[ni];
                    build_frame(d ? SYNC_B : SYNC_A, lead, 64'd0, n, 4);
                    run_scan(d, lead + 48, n, -1, 0,
                             (n == 0) ? "R7 zero length" : (d ? "R11 repeated sync" : "R3 sweep"));
                end

        // R8: non-zero junk before the header
        for (int d = 0; d < 2; d++) begin
            build_frame(d ? SYNC_B : SYNC_A, 8, 64'hC5, 9, 3);
            run_scan(d, 56, 9, -1, 0, "R8 sliding search");
        end

        // R2: scan ends in 0x59A6, next scan opens with the sync word
        for (int d = 0; d < 2; d++) begin
            sbits.delete();
            push({32'd0, d ? SYNC_B : SYNC_A}, 32);
            push(64'd16, 16);
            push(64'h59A6, 16);
            run_scan(d, 48, 16, -1, 0, "R2 stale tail scan");
            sbits.delete();
            push({32'd0, d ? SYNC_B : SYNC_A}, 32);
            push(64'd16, 16);
            push(64'h1234, 16);
            push(64'd0, 2);
            run_scan(d, 48, 16, -1, 0, "R2 scan after stale tail");
        end

        // R9: a full second header after the payload is ignored
        for (int d = 0; d < 2; d++) begin
            build_frame(d ? SYNC_B : SYNC_A, 0, 64'd0, 20, 0);
            push({32'd0, d ? SYNC_B : SYNC_A}, 32);
            push(64'd8, 16);
            push(64'd0, 8);
            run_scan(d, 48, 20, -1, 0, "R9 second header");
        end

        // R10 R1: update, sel low and tap_reset in the middle of a transfer
        for (int kind = 0; kind < 3; kind++) begin
            build_frame(SYNC_A, 0, 64'd0, 40, 4);
            run_scan(0, 48, 40, 58, kind, "R10 R1 abort");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule